// File: doc/BRIEF.md
# Variable Time-Delay Frequency Error Detector

This block is the detector stage of a phase-locked loop that measures frequency error by comparing an error signal with its own value one estimated grid period earlier. On each sample strobe it multiplies the incoming voltage sample by the cosine of the loop's estimated phase to form an error term. It stores that term in a circular history, and reads back the term written N samples before. N is derived from the loop's current frequency estimate so that N sample periods span one estimated period. The difference between the new and the delayed error, scaled by the frequency estimate, is the output z. This output approximates the derivative of the error with respect to the period. The loop filter drives z towards zero, and z is zero when the frequency error is zero.

The sample rate is 10 kHz and the lock range is 40 Hz to 60 Hz. The delay length is therefore kept between 165 and 250 samples, and the history holds 256 entries. The frequency estimate arrives as an unsigned fixed-point value in hertz with 8 fractional bits, and comes from the loop filter outside this block. Until enough history exists to cover the longest delay, the block flags itself as not ready and forces z to zero.

Top module: `vtd_freq_detector`

## Requirements
- R1: The error term is e = (vIn × cosIn) >>> 15, an arithmetic shift with floor rounding, kept as a 17-bit signed value. Both inputs are 16-bit signed, and cosIn is in Q1.15.
- R2: The delay length is N = round(2,560,000 / freqEst), where freqEst is in Q8.8 hertz and a half rounds up. N is clamped to the range [165, 250], and freqEst = 0 gives 250. After each strobe, tapLen shows the N that the next sample will use.
- R3: Sample k uses the N and the scale freqEst captured at sample k−1, with no interpolation. Before the first sample, N is 250 and the scale is 0.
- R4: When the history is ready, zOut = ((e(k) − e(k−N)) × scale) >>> 8 as a 27-bit signed value. It appears on the clock edge after the strobe edge, and zValid is high for that one cycle.
- R5: notReady is high until 250 samples have been written. For each of the first 250 samples, zOut is 0 (with zValid still pulsing), and notReady stays low once it has fallen.
- R6: While sampleValid is low, the inputs are ignored: zOut, tapLen and notReady hold, and zValid is low.
- R7: After reset, zOut is 0, zValid is 0, notReady is 1 and tapLen is 250.
- R8: The 256-entry history wraps around, so the delayed read stays correct for any N after more than 256 samples have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new input sample |
| vIn | input | 16 | Signed voltage sample |
| cosIn | input | 16 | Signed cosine of estimated phase, Q1.15 |
| freqEst | input | 16 | Unsigned frequency estimate, Q8.8 Hz |
| zOut | output | 27 | Signed scaled error difference |
| zValid | output | 1 | Pulses one cycle after a strobe |
| notReady | output | 1 | High while the history is still filling |
| tapLen | output | 8 | Delay length for the next sample |

## Verification
The hardest situation to reach from the ports is a delay length that changes while the history has wrapped. Reaching it needs hundreds of samples before any delayed read is trusted, followed by a tap that moves from sample to sample. The stimulus first fills the history at a steady 50 Hz estimate. It then ramps freqEst through a wide range, below, inside and above the lock range and including zero, over more than a thousand further samples with pseudo-random voltage and cosine values. Every sample therefore compares against a different delayed entry, across several wraps of the store.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

  // strobes handed from the control to the datapath for one sample
  typedef struct packed {
    logic wrEn;     // a sample is being taken this cycle
    logic zeroOut;  // history not yet deep enough, force zero output
  } vtd_strobe_t;

endpackage

// File: rtl/vtd_tap_ctrl.sv
module vtd_tap_ctrl
  import vtd_pkg::*;
#(
  parameter int SAMPLE_RATE = 10000,
  parameter int FRAC        = 8,
  parameter int FW          = 16,
  parameter int MIN_TAP     = 165,
  parameter int MAX_TAP     = 250,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic [FW-1:0] freqEst,
  output vtd_strobe_t   strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] tapLen,
  output logic          notReady
);

  localparam int unsigned NUM2 = 2 * SAMPLE_RATE * (2 ** FRAC);

  logic [AW-1:0] wrPtr;
  logic [AW-1:0] tapReg;
  logic [AW-1:0] fillCnt;
  logic [AW-1:0] tapNext;
  logic [31:0]   fWide;
  logic [31:0]   quot;

  // rounded period estimate in samples, then clamped to the lock range
  always_comb begin
    fWide = 32'(freqEst);
    if (fWide == 32'd0) begin
      quot = 32'(MAX_TAP);
    end else begin
      quot = (32'(NUM2) + fWide) / (fWide << 1);
    end
    if (quot > 32'(MAX_TAP)) begin
      tapNext = AW'(MAX_TAP);
    end else if (quot < 32'(MIN_TAP)) begin
      tapNext = AW'(MIN_TAP);
    end else begin
      tapNext = AW'(quot);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      tapReg  <= AW'(MAX_TAP);
      fillCnt <= '0;
    end else if (sampleValid) begin
      wrPtr  <= wrPtr + AW'(1);
      tapReg <= tapNext;
      if (fillCnt < AW'(MAX_TAP)) begin
        fillCnt <= fillCnt + AW'(1);
      end
    end
  end

  assign notReady     = (fillCnt < AW'(MAX_TAP));
  assign strb.wrEn    = sampleValid;
  assign strb.zeroOut = notReady;
  assign wrAddr       = wrPtr;
  assign rdAddr       = wrPtr - tapReg;
  assign tapLen       = tapReg;

  // R2: the registered tap never leaves the lock range
  a_r2_tap_range: assert property (@(posedge clk) disable iff (!rstN)
    (tapLen >= AW'(MIN_TAP)) && (tapLen <= AW'(MAX_TAP)));

  // R5: once ready, the block stays ready until reset
  a_r5_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !notReady |=> !notReady);

  // R6: without a strobe the tap holds
  a_r6_tap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(tapLen));

  // R8: each strobe advances the write position by one, wrapping
  a_r8_wr_advance: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> wrAddr == $past(wrAddr) + AW'(1));

endmodule

// File: rtl/vtd_datapath.sv
module vtd_datapath
  import vtd_pkg::*;
#(
  parameter int VW   = 16,
  parameter int CW   = 16,
  parameter int FW   = 16,
  parameter int FRAC = 8,
  parameter int AW   = 8,
  parameter int EW   = VW + 1,
  parameter int ZW   = EW + 1 + FW + 1 - FRAC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vtd_strobe_t          strb,
  input  logic [AW-1:0]        wrAddr,
  input  logic [AW-1:0]        rdAddr,
  input  logic signed [VW-1:0] vIn,
  input  logic signed [CW-1:0] cosIn,
  input  logic [FW-1:0]        freqEst,
  output logic signed [ZW-1:0] zOut,
  output logic                 zValid
);

  localparam int DEPTH = 1 << AW;
  localparam int MW    = VW + CW;
  localparam int DW    = EW + 1;
  localparam int PW    = DW + FW + 1;

  logic signed [EW-1:0] hist [DEPTH];
  logic [FW-1:0]        scaleReg;
  logic signed [MW-1:0] prod;
  logic signed [EW-1:0] eCur;
  logic signed [EW-1:0] eOld;
  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] scaled;
  logic signed [ZW-1:0] zNext;

  // error term: input times cosine of estimated phase
  always_comb begin
    prod   = vIn * cosIn;
    eCur   = EW'(prod >>> (CW - 1));
    eOld   = hist[rdAddr];
    diff   = DW'(eCur) - DW'(eOld);
    scaled = PW'(diff) * PW'($signed({1'b0, scaleReg}));
    zNext  = ZW'(scaled >>> FRAC);
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      hist[wrAddr] <= eCur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaleReg <= '0;
      zOut     <= '0;
      zValid   <= 1'b0;
    end else begin
      zValid <= strb.wrEn;
      if (strb.wrEn) begin
        scaleReg <= freqEst;
        zOut     <= strb.zeroOut ? '0 : zNext;
      end
    end
  end

  // R5: samples taken while filling give a zero output
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrEn && strb.zeroOut) |-> zOut == '0);

  // R6: no strobe, no change on the output
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrEn) |-> $stable(zOut));

  // R3: the scale snapshot only moves on a strobe
  a_r3_scale_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(scaleReg));

endmodule

// File: rtl/vtd_freq_detector.sv
module vtd_freq_detector
  import vtd_pkg::*;
#(
  parameter int SAMPLE_RATE = 10000,
  parameter int VW          = 16,
  parameter int CW          = 16,
  parameter int FW          = 16,
  parameter int FRAC        = 8,
  parameter int MIN_TAP     = 165,
  parameter int MAX_TAP     = 250,
  parameter int AW          = $clog2(MAX_TAP + 1),
  parameter int EW          = VW + 1,
  parameter int ZW          = EW + 1 + FW + 1 - FRAC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic signed [VW-1:0] vIn,
  input  logic signed [CW-1:0] cosIn,
  input  logic [FW-1:0]        freqEst,
  output logic signed [ZW-1:0] zOut,
  output logic                 zValid,
  output logic                 notReady,
  output logic [AW-1:0]        tapLen
);

  vtd_strobe_t   strb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  vtd_tap_ctrl #(
    .SAMPLE_RATE(SAMPLE_RATE), .FRAC(FRAC), .FW(FW),
    .MIN_TAP(MIN_TAP), .MAX_TAP(MAX_TAP), .AW(AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .freqEst(freqEst),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .tapLen(tapLen),
    .notReady(notReady)
  );

  vtd_datapath #(
    .VW(VW), .CW(CW), .FW(FW), .FRAC(FRAC), .AW(AW), .EW(EW), .ZW(ZW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .vIn(vIn), .cosIn(cosIn), .freqEst(freqEst), .zOut(zOut), .zValid(zValid)
  );

endmodule

// File: tb/vtd_freq_detector_bench.sv
module vtd_freq_detector_bench;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleValid = 1'b0;
  logic signed [15:0] vIn = '0;
  logic signed [15:0] cosIn = '0;
  logic [15:0]        freqEst = '0;
  logic signed [26:0] zOut;
  logic               zValid;
  logic               notReady;
  logic [7:0]         tapLen;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  longint eHist [0:4095];
  int     sampleIdx = 0;
  int     prevTap = 250;
  longint prevScale = 0;
  int unsigned rng = 32'h1234_5678;

  always #4 clk = ~clk;

  vtd_freq_detector u_vtd_freq_detector (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .vIn(vIn),
    .cosIn(cosIn), .freqEst(freqEst), .zOut(zOut), .zValid(zValid),
    .notReady(notReady), .tapLen(tapLen)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (sample %0d)", req, act, exp, sampleIdx);
    end
  endtask

  function automatic int unsigned nextRand();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int expTap(input longint f);
    longint q;
    if (f == 0) return 250;
    q = (5120000 + f) / (2 * f);
    if (q > 250) return 250;
    if (q < 165) return 165;
    return int'(q);
  endfunction

  // one sample: drive, strobe, check the registered result (R1 R3 R4 R5 R8),
  // then two idle cycles with junk inputs (R6)
  task automatic doSample(input logic signed [15:0] v, input logic signed [15:0] c,
                          input logic [15:0] f);
    longint e, eOld, zExp;
    logic signed [26:0] zHeld;
    logic [7:0] tapHeld;
    logic nrHeld;
    e = (longint'(v) * longint'(c)) >>> 15;
    eHist[sampleIdx] = e;
    if (sampleIdx < 250) zExp = 0;
    else begin
      eOld = eHist[sampleIdx - prevTap];
      zExp = ((e - eOld) * prevScale) >>> 8;
    end
    @(negedge clk);
    vIn = v; cosIn = c; freqEst = f; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    if (sampleIdx < 250)
      check(zOut == 0, "R5 zero while filling", longint'(zOut), 0);
    else
      check(longint'(zOut) == zExp, "R1/R4/R8 z value", longint'(zOut), zExp);
    check(zValid == 1'b1, "R4 zValid pulse", longint'(zValid), 1);
    check(notReady == (sampleIdx + 1 < 250), "R5 notReady", longint'(notReady),
          longint'(sampleIdx + 1 < 250));
    check(int'(tapLen) == expTap(longint'(f)), "R2 tap", longint'(tapLen),
          longint'(expTap(longint'(f))));
    prevTap = expTap(longint'(f));
    prevScale = longint'(f);
    sampleIdx++;
    zHeld = zOut; tapHeld = tapLen; nrHeld = notReady;
    vIn = 16'(nextRand()); cosIn = 16'(nextRand()); freqEst = 16'(nextRand());
    @(negedge clk);
    @(negedge clk);
    check(zValid == 1'b0, "R6 zValid low when idle", longint'(zValid), 0);
    check(zOut == zHeld && tapLen == tapHeld && notReady == nrHeld,
          "R6 hold when idle", longint'(zOut), longint'(zHeld));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(zOut == 0, "R7 zOut reset", longint'(zOut), 0);
    check(zValid == 0, "R7 zValid reset", longint'(zValid), 0);
    check(notReady == 1, "R7 notReady reset", longint'(notReady), 1);
    check(tapLen == 8'd250, "R7 tapLen reset", longint'(tapLen), 250);
    rstN = 1'b1;
    @(negedge clk);
    check(tapLen == 8'd250, "R7 tapLen after release", longint'(tapLen), 250);
    // fill at a steady 50 Hz estimate, extremes mixed in
    for (int i = 0; i < 260; i++) begin
      if (i == 5) doSample(-16'sd32768, -16'sd32768, 16'd12800);
      else if (i == 6) doSample(16'sd32767, -16'sd32768, 16'd12800);
      else doSample(16'(nextRand()), 16'(nextRand()), 16'd12800);
    end
    // ramp the estimate through and beyond the lock range (R2 R3 R8)
    for (int i = 0; i < 1300; i++) begin
      logic [15:0] f;
      f = 16'(6000 + i * 13);
      if (i == 400) f = 16'd0;
      if (i == 401) f = 16'd10240;   // exactly 40 Hz
      if (i == 402) f = 16'd15360;   // exactly 60 Hz
      if (i == 403) f = 16'hFFFF;
      doSample(16'(nextRand()), 16'(nextRand()), f);
    end
    done = 1'b1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule